// File: doc/BRIEF.md
# DMA Channel Address and Count Sequencer

This block holds the transfer state of one DMA channel and produces the physical bus address for every granted transfer. Software programs a page, a 16-bit start address, a 16-bit count and the transfer unit, which is byte or word. It can also select automatic reinitialisation. A single load strobe captures all of these values and arms the channel. Each later transfer strobe moves the channel forward by one unit. The address increments, the count decrements, and on the final transfer a terminal-count pulse is raised.

The 16-bit address counter never carries into the page. A transfer therefore wraps inside a 64 KiB window in byte mode, or inside a 128 KiB window in word mode. In word mode the address is shifted left by one bit, page bit 0 is dropped, and the bus address is always even. The stored count is one less than the number of transfers. The residue output gives the bytes still to move: the stored count plus one in 16-bit arithmetic, doubled in word mode. When a run without reinitialisation ends, the channel disarms and ignores further strobes. With reinitialisation selected, the channel reloads its programmed start values and keeps running. Request arbitration sits outside this block.

Top module: `dma_addr_seq`

## Requirements
- R1: After reset the channel is disarmed, and the outputs read phys_addr_o = 0, tc_o = 0 and residue_o = 1.
- R2: load_i captures page, address, count, word_mode_i and autoinit_i. The captured address and count become the current values, and the channel arms on the next clock.
- R3: In byte mode (word_mode_i = 0) phys_addr_o is {page[7:0], current_addr[15:0]}.
- R4: In word mode (word_mode_i = 1) phys_addr_o is {page[7:1], current_addr[15:0], 1'b0}, so page bit 0 has no effect.
- R5: Each xfer_i pulse on an armed channel without load_i adds 1 to the current address modulo 2^16 and subtracts 1 from the count modulo 2^16. The page bits of phys_addr_o never change because of this step.
- R6: tc_o is high exactly in a cycle where xfer_i is high, the channel is armed, load_i is low and the current count is 0x0000. A count of N therefore gives the pulse on transfer N+1.
- R7: When autoinit is off, the channel disarms at terminal count and afterwards shows residue 0. Later xfer_i pulses change neither phys_addr_o nor residue_o, and they raise no tc_o.
- R8: When autoinit is on, terminal count reloads the captured start address and count, and the channel stays armed.
- R9: residue_o is (count + 1) mod 2^16 in byte mode, and twice that value in word mode.
- R10: xfer_i on a disarmed channel, including the state right after reset, has no effect.
- R11: When load_i and xfer_i are high in the same cycle, the load wins, no step is taken and tc_o stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| load_i | input | 1 | Capture the programmed values and arm the channel |
| page_i | input | 8 | Page bits, physical address bits 23:16 |
| addr_i | input | 16 | Start address in units |
| count_i | input | 16 | Number of transfers minus one |
| word_mode_i | input | 1 | 1 selects 16-bit word units, 0 selects byte units |
| autoinit_i | input | 1 | Reload the start values at terminal count |
| xfer_i | input | 1 | A granted transfer takes place this cycle |
| phys_addr_o | output | 24 | Physical address of the current transfer |
| tc_o | output | 1 | Terminal-count pulse, high during the last transfer |
| residue_o | output | 17 | Bytes still to transfer |

## Verification
The assertions are evaluated on every cycle. They cover the per-transfer increment and decrement, the disarmed channel holding its state, reload or disarm at terminal count, tc_o appearing only during a transfer, and page bits that stay fixed while the address runs. Window wrap at 0xFFFF, the word-mode shift with page bit 0 dropped, the residue doubling, and precedence of load over transfer are shown only by the bench scenarios. There a behavioural model tracks the expected address, count and arming on every clock.

// File: rtl/dma_seq_pkg.sv
package dma_seq_pkg;

    typedef enum logic {
        UNIT_BYTE = 1'b0,
        UNIT_WORD = 1'b1
    } xfer_unit_e;

endpackage

// File: rtl/dma_seq_cfg.sv
module dma_seq_cfg
    import dma_seq_pkg::*;
#(
    parameter int PAGE_W = 8,
    parameter int ADDR_W = 16,
    parameter int CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [PAGE_W-1:0] page_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [CNT_W-1:0]  cnt_i,
    input  xfer_unit_e        unit_i,
    input  logic              auto_i,
    output logic [PAGE_W-1:0] page_o,
    output logic [ADDR_W-1:0] base_addr_o,
    output logic [CNT_W-1:0]  base_cnt_o,
    output xfer_unit_e        unit_o,
    output logic              auto_o
);

    typedef struct packed {
        logic [PAGE_W-1:0] page;
        logic [ADDR_W-1:0] base_addr;
        logic [CNT_W-1:0]  base_cnt;
        xfer_unit_e        unit;
        logic              autoinit;
    } cfg_t;

    cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (load) begin
            cfg_d.page      = page_i;
            cfg_d.base_addr = addr_i;
            cfg_d.base_cnt  = cnt_i;
            cfg_d.unit      = unit_i;
            cfg_d.autoinit  = auto_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q <= '{page: '0, base_addr: '0, base_cnt: '0,
                       unit: UNIT_BYTE, autoinit: 1'b0};
        end else begin
            cfg_q <= cfg_d;
        end
    end

    assign page_o      = cfg_q.page;
    assign base_addr_o = cfg_q.base_addr;
    assign base_cnt_o  = cfg_q.base_cnt;
    assign unit_o      = cfg_q.unit;
    assign auto_o      = cfg_q.autoinit;

    // Programmed values only move on a load (R2)
    p_cfg_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable(cfg_q));

endmodule

// File: rtl/dma_seq_ctr.sv
module dma_seq_ctr #(
    parameter int ADDR_W = 16,
    parameter int CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [ADDR_W-1:0] load_addr,
    input  logic [CNT_W-1:0]  load_cnt,
    input  logic              xfer,
    input  logic              auto_i,
    input  logic [ADDR_W-1:0] base_addr,
    input  logic [CNT_W-1:0]  base_cnt,
    output logic [ADDR_W-1:0] cur_addr,
    output logic [CNT_W-1:0]  cur_cnt,
    output logic              armed,
    output logic              tc
);

    localparam logic [CNT_W-1:0]  CNT_ZERO = '0;
    localparam logic [ADDR_W-1:0] ADDR_ONE = ADDR_W'(1);
    localparam logic [CNT_W-1:0]  CNT_ONE  = CNT_W'(1);

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [CNT_W-1:0]  cnt;
        logic              armed;
    } ctr_t;

    ctr_t ctr_d, ctr_q;
    logic step;
    logic last;

    always_comb begin
        ctr_d = ctr_q;
        step  = ctr_q.armed && xfer && !load;
        last  = step && (ctr_q.cnt == CNT_ZERO);
        if (load) begin
            ctr_d.addr  = load_addr;
            ctr_d.cnt   = load_cnt;
            ctr_d.armed = 1'b1;
        end else if (step) begin
            if (last && auto_i) begin
                ctr_d.addr = base_addr;
                ctr_d.cnt  = base_cnt;
            end else begin
                ctr_d.addr = ctr_q.addr + ADDR_ONE;
                ctr_d.cnt  = ctr_q.cnt - CNT_ONE;
                if (last) begin
                    ctr_d.armed = 1'b0;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctr_q <= '{addr: '0, cnt: '0, armed: 1'b0};
        end else begin
            ctr_q <= ctr_d;
        end
    end

    assign cur_addr = ctr_q.addr;
    assign cur_cnt  = ctr_q.cnt;
    assign armed    = ctr_q.armed;
    assign tc       = last;

    // Disarmed channel ignores transfers (R10)
    p_idle_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctr_q.armed && !load) |=> ($stable(ctr_q.addr) && $stable(ctr_q.cnt) && !ctr_q.armed));

    // Normal step moves address up and count down (R5)
    p_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (ctr_q.armed && xfer && !load && ctr_q.cnt != CNT_ZERO) |=>
        (ctr_q.addr == $past(ctr_q.addr) + ADDR_ONE) && (ctr_q.cnt == $past(ctr_q.cnt) - CNT_ONE));

    // Terminal count with reinitialisation restores the start values (R8)
    p_auto_reload_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (ctr_q.armed && xfer && !load && ctr_q.cnt == CNT_ZERO && auto_i) |=>
        (ctr_q.addr == base_addr) && (ctr_q.cnt == base_cnt) && ctr_q.armed);

    // Terminal count without reinitialisation disarms (R7)
    p_stop_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (ctr_q.armed && xfer && !load && ctr_q.cnt == CNT_ZERO && !auto_i) |=> !ctr_q.armed);

    // A load always arms the channel (R2)
    p_load_arms_r2: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> ctr_q.armed && (ctr_q.addr == $past(load_addr)));

endmodule

// File: rtl/dma_seq_fmt.sv
module dma_seq_fmt
    import dma_seq_pkg::*;
#(
    parameter int PAGE_W = 8,
    parameter int ADDR_W = 16,
    parameter int CNT_W  = 16,
    localparam int PHYS_W = PAGE_W + ADDR_W,
    localparam int RES_W  = CNT_W + 1
) (
    input  logic [PAGE_W-1:0] page,
    input  logic [ADDR_W-1:0] addr,
    input  logic [CNT_W-1:0]  cnt,
    input  xfer_unit_e        unit,
    output logic [PHYS_W-1:0] phys_addr,
    output logic [RES_W-1:0]  residue
);

    logic [CNT_W-1:0] units_left;

    always_comb begin
        units_left = cnt + CNT_W'(1);
        if (unit == UNIT_WORD) begin
            phys_addr = {page[PAGE_W-1:1], addr, 1'b0};
            residue   = {units_left, 1'b0};
        end else begin
            phys_addr = {page, addr};
            residue   = {1'b0, units_left};
        end
    end

endmodule

// File: rtl/dma_addr_seq.sv
module dma_addr_seq
    import dma_seq_pkg::*;
#(
    parameter int PAGE_W = 8,
    parameter int ADDR_W = 16,
    parameter int CNT_W  = 16,
    localparam int PHYS_W = PAGE_W + ADDR_W,
    localparam int RES_W  = CNT_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic [PAGE_W-1:0] page_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [CNT_W-1:0]  count_i,
    input  logic              word_mode_i,
    input  logic              autoinit_i,
    input  logic              xfer_i,
    output logic [PHYS_W-1:0] phys_addr_o,
    output logic              tc_o,
    output logic [RES_W-1:0]  residue_o
);

    logic [PAGE_W-1:0] page_q;
    logic [ADDR_W-1:0] base_addr_q;
    logic [CNT_W-1:0]  base_cnt_q;
    xfer_unit_e        unit_q;
    logic              auto_q;
    logic [ADDR_W-1:0] cur_addr;
    logic [CNT_W-1:0]  cur_cnt;
    logic              armed;

    dma_seq_cfg #(.PAGE_W(PAGE_W), .ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_cfg (
        .clk         (clk),
        .rst_n       (rst_n),
        .load        (load_i),
        .page_i      (page_i),
        .addr_i      (addr_i),
        .cnt_i       (count_i),
        .unit_i      (xfer_unit_e'(word_mode_i)),
        .auto_i      (autoinit_i),
        .page_o      (page_q),
        .base_addr_o (base_addr_q),
        .base_cnt_o  (base_cnt_q),
        .unit_o      (unit_q),
        .auto_o      (auto_q)
    );

    dma_seq_ctr #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_ctr (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (load_i),
        .load_addr (addr_i),
        .load_cnt  (count_i),
        .xfer      (xfer_i),
        .auto_i    (auto_q),
        .base_addr (base_addr_q),
        .base_cnt  (base_cnt_q),
        .cur_addr  (cur_addr),
        .cur_cnt   (cur_cnt),
        .armed     (armed),
        .tc        (tc_o)
    );

    dma_seq_fmt #(.PAGE_W(PAGE_W), .ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_fmt (
        .page      (page_q),
        .addr      (cur_addr),
        .cnt       (cur_cnt),
        .unit      (unit_q),
        .phys_addr (phys_addr_o),
        .residue   (residue_o)
    );

    // Terminal count only during a real transfer without load (R6, R11)
    p_tc_on_xfer_r6: assert property (@(posedge clk) disable iff (!rst_n)
        tc_o |-> (xfer_i && !load_i));

    // Address steps never reach the page bits (R5)
    p_window_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !load_i |=> $stable(phys_addr_o[PHYS_W-1:ADDR_W+1]));

    // A finished run without reinitialisation shows nothing left (R7)
    p_done_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (tc_o && !auto_q) |=> (residue_o == '0));

    // Word units always give an even bus address (R4)
    p_even_word_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (word_mode_i && load_i) |=> !phys_addr_o[0]);

endmodule

// File: tb/test_dma_addr_seq.sv
module test_dma_addr_seq;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        load_i = 1'b0;
    logic [7:0]  page_i = '0;
    logic [15:0] addr_i = '0;
    logic [15:0] count_i = '0;
    logic        word_mode_i = 1'b0;
    logic        autoinit_i = 1'b0;
    logic        xfer_i = 1'b0;
    logic [23:0] phys_addr_o;
    logic        tc_o;
    logic [16:0] residue_o;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    // behavioural model state
    int m_page = 0, m_base_addr = 0, m_base_cnt = 0, m_addr = 0, m_cnt = 0;
    bit m_word = 0, m_auto = 0, m_armed = 0;

    always #10 clk = ~clk;

    dma_addr_seq i_dma_addr_seq (
        .clk(clk), .rst_n(rst_n), .load_i(load_i), .page_i(page_i),
        .addr_i(addr_i), .count_i(count_i), .word_mode_i(word_mode_i),
        .autoinit_i(autoinit_i), .xfer_i(xfer_i), .phys_addr_o(phys_addr_o),
        .tc_o(tc_o), .residue_o(residue_o)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic int exp_phys();
        if (m_word) return ((m_page >> 1) << 17) | (m_addr << 1);
        return (m_page << 16) | m_addr;
    endfunction

    function automatic int exp_res();
        int u = (m_cnt + 1) & 16'hFFFF;
        return m_word ? u * 2 : u;
    endfunction

    // One clock: drive at negedge, compare outputs, advance model at posedge
    task automatic cyc(input string req, input bit ld, input int pg, input int ad,
                       input int ct, input bit wd, input bit au, input bit xf);
        bit exp_tc;
        @(negedge clk);
        load_i = ld; page_i = pg[7:0]; addr_i = ad[15:0]; count_i = ct[15:0];
        word_mode_i = wd; autoinit_i = au; xfer_i = xf;
        #2;
        exp_tc = xf && m_armed && !ld && (m_cnt == 0);
        chk(req, "phys_addr", int'(phys_addr_o), exp_phys());
        chk(req, "tc", int'(tc_o), int'(exp_tc));
        chk(req, "residue", int'(residue_o), exp_res());
        @(posedge clk);
        if (ld) begin
            m_page = pg & 8'hFF; m_base_addr = ad & 16'hFFFF; m_base_cnt = ct & 16'hFFFF;
            m_word = wd; m_auto = au; m_addr = m_base_addr; m_cnt = m_base_cnt; m_armed = 1;
        end else if (xf && m_armed) begin
            if (m_cnt == 0 && m_auto) begin
                m_addr = m_base_addr; m_cnt = m_base_cnt;
            end else begin
                if (m_cnt == 0) m_armed = 0;
                m_addr = (m_addr + 1) & 16'hFFFF;
                m_cnt = (m_cnt - 1) & 16'hFFFF;
            end
        end
    endtask

    task automatic run(input string req, input int n);
        for (int i = 0; i < n; i++) cyc(req, 0, 0, 0, 0, 0, 0, 1);
    endtask

    initial begin
        repeat (2) @(posedge clk);
        @(negedge clk);
        // R1: reset values
        chk("R1", "phys_addr", int'(phys_addr_o), 0);
        chk("R1", "tc", int'(tc_o), 0);
        chk("R1", "residue", int'(residue_o), 1);
        rst_n = 1'b1;
        // R10: transfers before any load are ignored
        run("R10", 3);
        // R2 R3 R5 R6: byte run wrapping at the window top
        cyc("R2", 1, 'h12, 'hFFFE, 3, 0, 0, 0);
        run("R3", 2);
        run("R5", 1);
        run("R6", 1);
        // R7: after completion further strobes do nothing
        run("R7", 3);
        // R4 R9: word mode, page bit 0 dropped, residue doubled
        cyc("R4", 1, 'h35, 'h7FFF, 1, 1, 0, 0);
        cyc("R9", 0, 0, 0, 0, 0, 0, 0);
        run("R4", 2);
        run("R7", 2);
        // R8: reinitialisation keeps the channel running
        cyc("R8", 1, 'hA0, 'h0100, 2, 0, 1, 0);
        run("R8", 8);
        // R11: load and transfer together
        cyc("R11", 1, 'h07, 'h4000, 5, 0, 0, 1);
        run("R11", 1);
        // R9: full-size count reads as residue 0 and wraps
        cyc("R9", 1, 'h01, 'hFFFF, 'hFFFF, 0, 0, 0);
        run("R9", 3);
        // R5 R9: longer word run with autoinit, wrapping in 128K window
        cyc("R5", 1, 'hFF, 'hFF00, 299, 1, 1, 0);
        run("R5", 650);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule